// File: doc/BRIEF.md
# Periodic System Tick Timer

A down-counting interval timer for periodic operating-system ticks, controlled through four 32-bit registers on a simple word-addressed register bus. Software loads a reload value, selects whether the counter advances on every core clock or only on cycles where a reference-tick enable input is high, and enables counting. The counter steps down once per selected tick. Each time it steps from 1 to 0 it sets a sticky status flag and, if interrupts are enabled, emits a one-cycle interrupt request. On the next tick it reloads, so the event period is reload+1 ticks.

The bus carries a 2-bit word index, separate read and write strobes and 32-bit data. Read data is combinational and valid in the cycle of the read strobe. Read and write side effects take place at the clock edge that ends that cycle. Calibration constants are elaboration parameters. When the block is built without a reference tick, the clock-source selection is fixed to the core clock.

Top module: `tick_timer`

## Requirements
- R1: Word index 1 holds the reload value. Only bits [CNT_W-1:0] are stored, write data above those bits is dropped, and the upper bits read as zero.
- R2: While counting, each selected tick lowers the counter by one. A tick that finds the counter at 0 loads the reload value, so the 1-to-0 event repeats every reload+1 ticks. The current value is read at word index 2.
- R3: Word index 0 is control/status, with bit 0 run enable, bit 1 interrupt enable, bit 2 clock source (1 = core clock, 0 = reference tick) and bit 16 the sticky zero flag. All other bits read as zero. The flag is set by every 1-to-0 step of the counter.
- R4: A read of word index 0 returns the flag as it was and clears it at the end of that cycle. If a 1-to-0 step happens in the same cycle, the flag stays set.
- R5: A write to word index 2 with any data sets the counter to 0 and clears the flag. The next tick loads the reload value.
- R6: The interrupt output is high for exactly one cycle after each 1-to-0 step while interrupt enable is 1, and stays low while it is 0.
- R7: While run enable is 0, the counter holds its value.
- R8: With clock source 0, the counter advances only in cycles where ref_tick is high. With clock source 1, it advances every cycle.
- R9: Word index 3 is read-only and returns the calibration word: bit 31 no-reference, bit 30 skew, bits [23:0] ticks per 10 ms. Writes to it have no effect.
- R10: With CAL_NOREF set, control bit 2 always reads 1 and the counter advances every core cycle, whatever is written to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable, one core cycle per reference tick |
| bus_addr | input | 2 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, zero otherwise |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The counter is run with a short reload on the core clock, which exposes any off-by-one in the reload+1 period. It is also run with a reference tick that is high only one cycle in three, which separates the two clock-source paths. A long reload, with status read back-to-back after an event, shows that the read clears the flag and that the first read still returns it set. Writes of arbitrary data to the current-value register while the counter is stopped distinguish the clear-to-zero behaviour from a load of the data. The hold-while-disabled behaviour is checked in the same state. A second instance built without a reference tick shows the forced clock source.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      REG_CTRL    = 2'd0,
      REG_RELOAD  = 2'd1,
      REG_CURRENT = 2'd2,
      REG_CALIB   = 2'd3
   } reg_sel_e;

   localparam int unsigned BIT_RUN   = 0;
   localparam int unsigned BIT_IE    = 1;
   localparam int unsigned BIT_SRC   = 2;
   localparam int unsigned BIT_FLAG  = 16;
   localparam int unsigned BIT_SKEW  = 30;
   localparam int unsigned BIT_NOREF = 31;
   localparam int unsigned TENMS_W   = 24;

endpackage

// File: rtl/tick_timer_down_cnt.sv
module tick_timer_down_cnt #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clear,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         hit
);

   localparam logic [W-1:0] ONE = W'(1);

   assign hit = tick & ~clear & (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (clear)        cnt <= '0;
      else if (tick) begin
         if (cnt == '0)      cnt <= reload;
         else                cnt <= cnt - ONE;
      end
   end

   // R2: a tick at zero loads the reload value
   p_reload_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clear && cnt == '0) |=> cnt == $past(reload));

   // R7: no tick and no clear leaves the count unchanged
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear) |=> $stable(cnt));

   // R5: a clear lands on zero
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);

   // R3: an event is always followed by a zero count
   p_hit_lands_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> cnt == '0);

endmodule

// File: rtl/tick_timer_status.sv
module tick_timer_status (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic irq_en,
   input  logic rd_clr,
   input  logic wr_clr,
   output logic flag,
   output logic irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (hit)                  flag <= 1'b1;
         else if (rd_clr | wr_clr) flag <= 1'b0;
         irq <= hit & irq_en;
      end
   end

   // R6: the request never lasts two cycles
   p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R6: a request is always accompanied by the flag
   p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   // R4: a status read without a new event clears the flag
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !hit) |=> !flag);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned       CNT_W     = 24,
   parameter logic [TENMS_W-1:0] CAL_TENMS = 24'd0,
   parameter bit                CAL_SKEW  = 1'b0,
   parameter bit                CAL_NOREF = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ref_tick,
   input  logic [1:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);

   localparam logic [31:0] CALIB_WORD = {CAL_NOREF, CAL_SKEW, 6'b0, CAL_TENMS};

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("tick_timer: CNT_W must lie in 2..24");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(bus_addr);

   logic wr_ctrl, wr_reload, wr_current, rd_ctrl;
   assign wr_ctrl    = bus_wr & (sel == REG_CTRL);
   assign wr_reload  = bus_wr & (sel == REG_RELOAD);
   assign wr_current = bus_wr & (sel == REG_CURRENT);
   assign rd_ctrl    = bus_rd & (sel == REG_CTRL);

   logic             run_q, ie_q, src_q;
   logic [CNT_W-1:0] reload_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ie_q     <= 1'b0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[BIT_RUN];
            ie_q  <= bus_wdata[BIT_IE];
         end
         if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   generate
      if (CAL_NOREF) begin : g_src_fixed
         assign src_q = 1'b1;
      end else begin : g_src_reg
         always_ff @(posedge clk) begin
            if (!rst_n)       src_q <= 1'b0;
            else if (wr_ctrl) src_q <= bus_wdata[BIT_SRC];
         end
      end
   endgenerate

   logic tick;
   assign tick = run_q & (src_q | ref_tick);

   logic [CNT_W-1:0] cnt;
   logic             hit, flag;

   tick_timer_down_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .clear  (wr_current),
      .reload (reload_q),
      .cnt    (cnt),
      .hit    (hit)
   );

   tick_timer_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit),
      .irq_en (ie_q),
      .rd_clr (rd_ctrl),
      .wr_clr (wr_current),
      .flag   (flag),
      .irq    (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            REG_CTRL: begin
               bus_rdata[BIT_RUN]  = run_q;
               bus_rdata[BIT_IE]   = ie_q;
               bus_rdata[BIT_SRC]  = src_q;
               bus_rdata[BIT_FLAG] = flag;
            end
            REG_RELOAD:  bus_rdata = 32'(reload_q);
            REG_CURRENT: bus_rdata = 32'(cnt);
            REG_CALIB:   bus_rdata = CALIB_WORD;
            default:     bus_rdata = '0;
         endcase
      end
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[31:CNT_W];

endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;

   localparam logic [23:0] TENMS = 24'h01D4C0;
   localparam logic [31:0] CALIB_EXP = {1'b0, 1'b1, 6'b0, TENMS};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, bus_rdata2;
   logic        irq, irq2;

   always #2.5 clk = ~clk;

   tick_timer #(.CNT_W(24), .CAL_TENMS(TENMS), .CAL_SKEW(1'b1), .CAL_NOREF(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq));

   tick_timer #(.CNT_W(24), .CAL_TENMS(24'd0), .CAL_SKEW(1'b0), .CAL_NOREF(1'b1)) dut2 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata2), .irq(irq2));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural reference model of the main instance
   logic [23:0] m_cnt = '0, m_reload = '0;
   bit m_run = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return {15'b0, m_flag, 13'b0, m_src, m_ie, m_run};
         2'd1:    return {8'b0, m_reload};
         2'd2:    return {8'b0, m_cnt};
         default: return CALIB_EXP;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_reload = '0; m_run = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
      end else begin
         bit tk, ev;
         tk = m_run && (m_src || ref_tick);
         ev = 0;
         if (bus_rd && bus_addr == 2'd0) m_flag = 0;
         if (bus_wr && bus_addr == 2'd2) begin
            m_cnt = '0; m_flag = 0;
         end else if (tk) begin
            if (m_cnt == 0) m_cnt = m_reload;
            else begin
               if (m_cnt == 1) ev = 1;
               m_cnt = m_cnt - 1;
            end
         end
         if (ev) m_flag = 1;
         m_irq = ev && m_ie;
         if (bus_wr && bus_addr == 2'd0) begin
            m_run = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
         end
         if (bus_wr && bus_addr == 2'd1) m_reload = bus_wdata[23:0];
      end
   end

   // every-clock comparison of the interrupt output (R6)
   always @(negedge clk) if (rst_n) chk("R6 irq vs model", {31'b0, irq}, {31'b0, m_irq});

   bit ref_mode = 0;
   int ref_phase = 0;
   always @(negedge clk) begin
      if (ref_mode) begin
         ref_phase = (ref_phase + 1) % 3;
         ref_tick = (ref_phase == 0);
      end else ref_tick = 1'b0;
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v, output logic [31:0] v2);
      string tag;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      v = bus_rdata; v2 = bus_rdata2;
      case (a)
         2'd0:    tag = "R3 ctrl read vs model";
         2'd1:    tag = "R1 reload read vs model";
         2'd2:    tag = "R2 R8 current read vs model";
         default: tag = "R9 calib read vs model";
      endcase
      chk(tag, v, exp_read(a));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (irq) return;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v, v2, a1, a2;
      int n;
      idle(3);
      rst_n = 1'b1;
      // reset state
      rd(2'd0, v, v2); chk("R3 reset ctrl", v, 32'h0);
      rd(2'd1, v, v2); chk("R1 reset reload", v, 32'h0);
      rd(2'd2, v, v2); chk("R2 reset current", v, 32'h0);
      rd(2'd3, v, v2); chk("R9 calib word", v, CALIB_EXP);

      // R1: upper write bits dropped
      wr(2'd1, 32'hFF00_0005);
      rd(2'd1, v, v2); chk("R1 reload masked", v, 32'h5);

      // R8 / R10: reference source with no reference ticks
      wr(2'd0, 32'h0000_0001);
      idle(5);
      rd(2'd2, v, v2); chk("R8 no ref ticks no count", v, 32'h0);
      rd(2'd0, v, v2); chk("R10 forced source bit", v2 & 32'h7, 32'h5);
      rd(2'd2, v, a1);
      rd(2'd2, v, a2); chk("R10 counts on core clock", {31'b0, a1 != a2}, 32'h1);

      // R8: reference tick one cycle in three
      ref_mode = 1;
      idle(40);
      rd(2'd2, v, v2);
      rd(2'd0, v, v2);
      idle(20);
      ref_mode = 0;

      // R2 R6: core clock, interrupts on, period reload+1
      wr(2'd0, 32'h0000_0007);
      wait_irq();
      n = 0;
      do begin @(negedge clk); n++; end while (!irq && n < 100);
      chk("R2 period reload+1", n, 6);
      idle(13);

      // R4: flag read then cleared
      wr(2'd1, 32'd200);
      wr(2'd2, 32'h0);
      wait_irq();
      rd(2'd0, v, v2); chk("R3 flag set after event", (v >> 16) & 1, 32'h1);
      rd(2'd0, v, v2); chk("R4 flag cleared by read", (v >> 16) & 1, 32'h0);

      // R5: write to current clears flag and count
      wait_irq();
      wr(2'd0, 32'h0000_0006);
      rd(2'd2, a1, v2);
      idle(4);
      rd(2'd2, a2, v2); chk("R7 hold when disabled", a2, a1);
      wr(2'd2, 32'hDEAD_BEEF);
      rd(2'd2, v, v2); chk("R5 current cleared", v, 32'h0);
      rd(2'd0, v, v2); chk("R5 flag cleared by write", (v >> 16) & 1, 32'h0);
      idle(3);
      rd(2'd2, v, v2); chk("R7 zero held when disabled", v, 32'h0);

      // R9: calib write ignored
      wr(2'd3, 32'h0000_0000);
      rd(2'd3, v, v2); chk("R9 calib unchanged", v, CALIB_EXP);

      // R6: interrupt enable off, events still flag
      wr(2'd1, 32'd5);
      wr(2'd0, 32'h0000_0005);
      n = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq) n++; end
      chk("R6 no irq when disabled", n, 0);
      rd(2'd0, v, v2); chk("R3 flag without irq", (v >> 16) & 1, 32'h1);

      idle(5);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule